// File: doc/BRIEF.md
# Write-Through Data Cache with Per-Word Valid Bits

This block is a direct-mapped data cache that sits between a processor load/store port and a single-word memory port. Each cache line is split into one-word subblocks, and every subblock carries its own valid bit. Because every store is also sent on to memory, a single-word store can write its tag and data into the line straight away, with no tag lookup first. If the store's tag differs from the stored tag, the line changes owner and its other words are marked invalid. Nothing is lost, because memory already holds their current values.

A load hits only when the stored tag matches and the addressed word is valid. On a hit, the data comes back in the same cycle the request is accepted. On a load miss, only the requested word is fetched from memory. That word is placed in the line under the same tag-replacement rule that stores use, and it is passed to the processor in the cycle memory acknowledges. One request is outstanding at a time. While a memory transaction is open, the cache tells the processor it cannot accept a new request.

Word addresses are split from the least significant end as follows: bits [1:0] select the subblock, the next `IDX_W` bits select the line, and the remaining upper bits form the tag.

Top module: `wt_subblock_cache`

## Requirements
- R1: After reset every valid bit is clear. The first load to any address is therefore a miss: it gets no response in its acceptance cycle and starts a memory read.
- R2: A load whose tag matches and whose subblock (address bits [1:0]) is valid gives `rsp_valid` in its acceptance cycle with the stored word, and it starts no memory transaction.
- R3: A load miss makes exactly one memory read, at the requested word address. Its response arrives in the cycle of `mem_ack` and carries `mem_rdata`. Neighbouring words of the line are not fetched, so a later load to a neighbour is still a miss.
- R4: A store whose tag matches a valid subblock overwrites that word, and the word stays valid. A later load to it hits and returns the new data.
- R5: A store whose tag matches but whose subblock is invalid writes the word and makes it valid. A later load to it hits.
- R6: A store with a mismatching tag puts its own tag in the line, writes and validates its word, and invalidates every other subblock of the line. A later load to another word of the line misses, under the new tag or the old one.
- R7: Every store is forwarded to memory as one write, with `mem_we`=1 and the store's address and data. The store's response comes with `mem_ack`. Data displaced from the cache is still read back correctly from memory.
- R8: While a memory transaction is open, `req_ready` is 0. `mem_req` stays high with a stable address until `mem_ack`.
- R9: A word filled by a load miss is valid afterwards. If the fill's tag differed from the line's tag, the fill follows the R6 rule and invalidates the line's other words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Response for the accepted request |
| rsp_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory transaction open |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
On a load miss, two things happen in the same `mem_ack` cycle: the response goes to the processor, and the fetched word is written into the line, possibly replacing the tag and invalidating the neighbours. The bench provokes this with loads that miss on lines owned by another tag. It judges the result by what follows. An immediate re-load must hit with no memory read, and it must return the same word. A load to a former neighbour must miss and be served from memory. The memory model counts reads and writes, so the bench can tell a fetched word from a hit.

// File: rtl/wt_subblock_cache.sv
module wt_subblock_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int SUBS  = 1 << SUB_W;
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - SUB_W;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} state_t;
  state_t state_q;

  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [SUBS-1:0]   valid_q [LINES];
  logic [DATA_W-1:0] data_q  [LINES*SUBS];
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;

  wire [SUB_W-1:0] r_sub = req_addr[SUB_W-1:0];
  wire [IDX_W-1:0] r_idx = req_addr[SUB_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire r_hit = valid_q[r_idx][r_sub] && (tag_q[r_idx] == r_tag);

  wire idle = (state_q == S_IDLE);
  wire fire = req_valid && idle;

  wire              upd_en   = (fire && req_write) || (state_q == S_RD && mem_ack);
  wire [ADDR_W-1:0] upd_addr = idle ? req_addr : pend_addr_q;
  wire [DATA_W-1:0] upd_data = idle ? req_wdata : mem_rdata;
  wire [SUB_W-1:0]  u_sub = upd_addr[SUB_W-1:0];
  wire [IDX_W-1:0]  u_idx = upd_addr[SUB_W +: IDX_W];
  wire [TAG_W-1:0]  u_tag = upd_addr[ADDR_W-1 -: TAG_W];

  assign req_ready = idle;
  assign rsp_valid = idle ? (req_valid && !req_write && r_hit) : mem_ack;
  assign rsp_rdata = idle ? data_q[{r_idx, r_sub}] : mem_rdata;
  assign mem_req   = !idle;
  assign mem_we    = (state_q == S_WR);
  assign mem_addr  = pend_addr_q;
  assign mem_wdata = pend_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (fire && (req_write || !r_hit)) begin
          state_q     <= req_write ? S_WR : S_RD;
          pend_addr_q <= req_addr;
          pend_data_q <= req_wdata;
        end
        default: if (mem_ack) state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        valid_q[i] <= '0;
        tag_q[i]   <= '0;
      end
    end else if (upd_en) begin
      if (tag_q[u_idx] == u_tag) begin
        valid_q[u_idx][u_sub] <= 1'b1;
      end else begin
        tag_q[u_idx]   <= u_tag;
        valid_q[u_idx] <= SUBS'(1) << u_sub;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) data_q[{u_idx, u_sub}] <= upd_data;
  end

  a_r8_busy_blocks_requests: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r7_store_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=>
      (mem_req && mem_we && mem_addr == $past(req_addr) && mem_wdata == $past(req_wdata)));
  a_r2_hit_no_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && rsp_valid) |=> !mem_req);
  a_r3_miss_fetches_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !rsp_valid) |=>
      (mem_req && !mem_we && mem_addr == $past(req_addr)));
  a_r3_fill_response: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |-> (rsp_valid && rsp_rdata == mem_rdata));
endmodule

// File: tb/wt_subblock_cache_tb_top.sv
module wt_subblock_cache_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_req, mem_we;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  wt_subblock_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [DW-1:0] mem_model [1 << AW];

  typedef struct { bit is_wr; logic [DW-1:0] data; string tag; } exp_t;
  exp_t exp_q [$];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // memory model: acks one cycle after the request is seen
  initial begin
    for (int i = 0; i < (1 << AW); i++) mem_model[i] = 32'hA000_0000 + i;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        @(negedge clk);
        mem_ack = 1'b1;
        mem_rdata = mem_model[mem_addr];
        if (mem_we) begin mem_model[mem_addr] = mem_wdata; wr_cnt++; end
        else rd_cnt++;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  // monitor: pops the scoreboard on each response
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) check(1'b0, "unexpected response", rsp_rdata, '0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (!e.is_wr) check(rsp_rdata === e.data, e.tag, rsp_rdata, e.data);
        end
      end
    end
  end

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input bit exp_hit, input string tag);
    int rd0, wr0;
    exp_t e;
    rd0 = rd_cnt; wr0 = wr_cnt;
    e.is_wr = wr; e.data = wr ? d : mem_model[a]; e.tag = tag;
    @(negedge clk);
    if (!wr && exp_hit) e.data = e.data; // hit data set by caller via mem_model mirror
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #6;
    if (!wr) check(rsp_valid == exp_hit, {tag, " hit/miss"}, {31'b0, rsp_valid}, {31'b0, exp_hit});
    @(negedge clk);
    req_valid = 1'b0;
    if (wr || !exp_hit)
      check(req_ready == 1'b0, "R8 busy during memory op", {31'b0, req_ready}, 32'd0);
    while (exp_q.size() != 0) @(negedge clk);
    if (wr) check(wr_cnt - wr0 == 1, "R7 one memory write", wr_cnt - wr0, 1);
    else check(rd_cnt - rd0 == (exp_hit ? 0 : 1), {tag, " memory reads"},
               rd_cnt - rd0, exp_hit ? 0 : 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check(req_ready && !mem_req && !rsp_valid, "R1 reset state",
          {29'b0, req_ready, mem_req, rsp_valid}, 32'b100);
    // tag 0, index 1: addresses 0x004..0x007; tag 1 same line: 0x044..0x047
    op(0, 10'h005, '0, 0, "R1 first load misses");
    op(0, 10'h005, '0, 1, "R2 load hit");
    op(0, 10'h006, '0, 0, "R3 neighbour not prefetched");
    op(0, 10'h006, '0, 1, "R9 filled word hits");
    op(0, 10'h007, '0, 0, "R3 single-word fill");
    op(1, 10'h005, 32'h1111_1111, 0, "R4 store valid word");
    op(0, 10'h005, '0, 1, "R4 new data hit");
    op(1, 10'h004, 32'h2222_2222, 0, "R5 store invalid word");
    op(0, 10'h004, '0, 1, "R5 word now valid");
    op(1, 10'h045, 32'h3333_3333, 0, "R6 store new tag");
    op(0, 10'h045, '0, 1, "R6 stored word hits");
    op(0, 10'h046, '0, 0, "R6 new-tag neighbour invalid");
    op(0, 10'h004, '0, 0, "R6 old tag evicted");
    op(0, 10'h004, '0, 1, "R7 displaced store data from memory");
    op(0, 10'h045, '0, 0, "R9 fill replaced tag");
    op(0, 10'h005, '0, 0, "R9 fill cleared neighbours");
    op(0, 10'h005, '0, 1, "R7 memory kept store");
    for (int i = 0; i < 16; i++) begin
      op(0, AW'(i * 4 + 2 + 128), '0, 0, "R1 other lines start invalid");
      op(0, AW'(i * 4 + 2 + 128), '0, 1, "R2 other lines hit");
    end
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule